// File: doc/BRIEF.md
# Dual-Channel Digitizer Synchronization Controller

This block sits between two pipelined charge-integrating digitizers and a serializer. On every bunch crossing it takes one 9-bit sample word from each digitizer. It checks that each channel's capacitor identifier steps through its four-value rotation, and that the two channels agree with each other. It also runs a bunch-crossing counter that is checked against an incoming orbit marker. It then packs both samples, a 2-bit error field and the low counter bits into one 32-bit frame per crossing.

Control inputs can force both digitizers onto a chosen range, replace the frame with a fixed test pattern, request a digitizer reset, and fire a test pulse. A digitizer reset goes out only when the crossing counter reaches a set slot. Errors are held until a separate set slot, where they appear in the frame and are then cleared. The orbit length and both slots are parameters.

Top module: `dual_digitizer_sync`

## Requirements
- R1: The frame registered at each clock edge holds channel A's sample word in bits [8:0], channel B's sample word in bits [17:9], the error field in [19:18] and the crossing counter value in [31:20], zero-extended. The counter value is the one held before that edge. Each sample word is laid out as mantissa [4:0], range [6:5] and capacitor ID [8:7].
- R2: If the two channels' capacitor IDs differ on a crossing, the capacitor error flag is set. This check does not run on the crossing where the digitizer reset output is high.
- R3: Each channel's capacitor ID must equal its previous ID plus one, modulo 4, or the capacitor error flag is set. After reset, and after a crossing with the digitizer reset output high, the next ID received is taken as the new start and is not checked.
- R4: The crossing counter starts at 0, counts up by one per clock and wraps from ORBIT_LEN-1 to 0.
- R5: An orbit marker arriving while the counter is not 0 sets the bunch error flag. The counter itself is not moved by the marker.
- R6: The range-force enable and the 2-bit range value appear on the range outputs one clock after they are applied.
- R7: While pattern mode is set, the frame registered at that edge is the PATTERN parameter, in place of the packed data.
- R8: A reset request is held pending. The digitizer reset output is then high for exactly one clock, right after the edge on which the counter value equals RESET_BX with a request pending.
- R9: The error flags are sticky. Error field bit 18 (capacitor) and bit 19 (bunch) are non-zero only in the frame built while the counter equals REPORT_BX. That frame shows the flags gathered before that crossing, and the flags are then cleared. An error detected on the report crossing itself is held for the next report.
- R10: The test-pulse output is high for one clock after each clock on which the pulse request is high.
- R11: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_a_word | input | 9 | Channel A sample word |
| ch_b_word | input | 9 | Channel B sample word |
| orbit_mark | input | 1 | Orbit (beam turn) marker |
| force_range_en | input | 1 | Request forced range on both digitizers |
| force_range_val | input | 2 | Range value to force |
| pattern_en | input | 1 | Send fixed test pattern instead of data |
| reset_req | input | 1 | Request a digitizer reset at the reset slot |
| pulse_req | input | 1 | Request a test pulse |
| frame_o | output | 32 | Packed frame toward the serializer |
| dig_range_force_o | output | 1 | Forced-range enable to the digitizers |
| dig_range_o | output | 2 | Forced range value to the digitizers |
| dig_reset_o | output | 1 | Digitizer reset, one clock wide |
| test_pulse_o | output | 1 | Test-pulse trigger |

## Verification
Every result is due one clock after the inputs that cause it. This covers the frame, the range outputs and the test pulse. The digitizer reset is also due one clock after the edge that sees the reset slot. An error shows up only in the frame of the next report crossing. The bench drives inputs on the falling edge and moves a behavioural model forward by one crossing. After the next rising edge, it compares every output against the model at the following falling edge. This means each expected value is always matched with the single register stage in front of it.

// File: rtl/qsync_pkg.sv
package qsync_pkg;
   localparam int MANT_W   = 5;
   localparam int RANGE_W  = 2;
   localparam int CAP_W    = 2;
   localparam int SAMPLE_W = MANT_W + RANGE_W + CAP_W;
   localparam int FRAME_W  = 32;
   localparam int ERR_W    = 2;
   localparam int BXF_W    = FRAME_W - 2 * SAMPLE_W - ERR_W;
   localparam int N_CH     = 2;

   typedef struct packed {
      logic [CAP_W-1:0]   capid;
      logic [RANGE_W-1:0] rng;
      logic [MANT_W-1:0]  mant;
   } sample_t;
endpackage

// File: rtl/qsync_capid_track.sv
module qsync_capid_track
   import qsync_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CAP_W-1:0] cap_i,
   output logic             rot_err_o
);
   logic             valid_q;
   logic [CAP_W-1:0] prev_q;
   logic [CAP_W-1:0] want;

   assign want      = prev_q + 1'b1;
   assign rot_err_o = valid_q && !restart && (cap_i != want);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         prev_q  <= '0;
      end else if (restart) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b1;
         prev_q  <= cap_i;
      end
   end

   // R3: the first ID after a restart is never flagged
   a_r3_restart_free: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !rot_err_o);
endmodule

// File: rtl/qsync_bx_counter.sv
module qsync_bx_counter #(
   parameter int ORBIT_LEN = 3564,
   parameter int BXW       = $clog2(ORBIT_LEN)
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [BXW-1:0] bx_o
);
   localparam logic [BXW-1:0] LAST = BXW'(ORBIT_LEN - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)             bx_o <= '0;
      else if (bx_o == LAST)  bx_o <= '0;
      else                    bx_o <= bx_o + 1'b1;
   end

   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_o != LAST) |=> (bx_o == BXW'($past(bx_o) + 1'b1)));
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_o == LAST) |=> (bx_o == '0));
endmodule

// File: rtl/qsync_frame_pack.sv
module qsync_frame_pack
   import qsync_pkg::*;
#(
   parameter int                 BXW     = 12,
   parameter logic [FRAME_W-1:0] PATTERN = 32'hA5C3_5A3C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pattern_en,
   input  sample_t            smp_a,
   input  sample_t            smp_b,
   input  logic [ERR_W-1:0]   err_field,
   input  logic [BXW-1:0]     bx,
   output logic [FRAME_W-1:0] frame_o
);
   logic [BXF_W-1:0] bx_field;

   generate
      if (BXW >= BXF_W) begin : g_bx_trunc
         assign bx_field = bx[BXF_W-1:0];
      end else begin : g_bx_pad
         assign bx_field = {{(BXF_W-BXW){1'b0}}, bx};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          frame_o <= '0;
      else if (pattern_en) frame_o <= PATTERN;
      else                 frame_o <= {bx_field, err_field, smp_b, smp_a};
   end

   a_r7_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      pattern_en |=> (frame_o == PATTERN));
endmodule

// File: rtl/dual_digitizer_sync.sv
module dual_digitizer_sync
   import qsync_pkg::*;
#(
   parameter int                 ORBIT_LEN = 3564,
   parameter int                 RESET_BX  = 10,
   parameter int                 REPORT_BX = 100,
   parameter logic [FRAME_W-1:0] PATTERN   = 32'hA5C3_5A3C
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] ch_a_word,
   input  logic [SAMPLE_W-1:0] ch_b_word,
   input  logic                orbit_mark,
   input  logic                force_range_en,
   input  logic [RANGE_W-1:0]  force_range_val,
   input  logic                pattern_en,
   input  logic                reset_req,
   input  logic                pulse_req,
   output logic [FRAME_W-1:0]  frame_o,
   output logic                dig_range_force_o,
   output logic [RANGE_W-1:0]  dig_range_o,
   output logic                dig_reset_o,
   output logic                test_pulse_o
);
   localparam int BXW = $clog2(ORBIT_LEN);
   localparam logic [BXW-1:0] RST_SLOT = BXW'(RESET_BX);
   localparam logic [BXW-1:0] REP_SLOT = BXW'(REPORT_BX);

   generate
      if (ORBIT_LEN < 2 || RESET_BX >= ORBIT_LEN || REPORT_BX >= ORBIT_LEN) begin : g_bad_cfg
         $error("dual_digitizer_sync: slots must lie inside an orbit of at least 2");
      end
   endgenerate

   sample_t          smp [N_CH];
   logic [N_CH-1:0]  rot_err;
   logic [BXW-1:0]   bx;
   logic             sync_mis, cap_err, bunch_err, report, fire;
   logic [ERR_W-1:0] sticky_q, new_err, err_field;
   logic             pend_q;

   assign smp[0] = sample_t'(ch_a_word);
   assign smp[1] = sample_t'(ch_b_word);

   generate
      for (genvar ch = 0; ch < N_CH; ch++) begin : g_track
         qsync_capid_track u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart   (dig_reset_o),
            .cap_i     (smp[ch].capid),
            .rot_err_o (rot_err[ch])
         );
      end
   endgenerate

   qsync_bx_counter #(.ORBIT_LEN(ORBIT_LEN), .BXW(BXW)) u_bx (
      .clk   (clk),
      .rst_n (rst_n),
      .bx_o  (bx)
   );

   assign sync_mis  = !dig_reset_o && (smp[0].capid != smp[1].capid);
   assign cap_err   = sync_mis || (|rot_err);
   assign bunch_err = orbit_mark && (bx != '0);
   assign new_err   = {bunch_err, cap_err};
   assign report    = (bx == REP_SLOT);
   assign err_field = report ? sticky_q : '0;
   assign fire      = pend_q && (bx == RST_SLOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sticky_q          <= '0;
         pend_q            <= 1'b0;
         dig_reset_o       <= 1'b0;
         test_pulse_o      <= 1'b0;
         dig_range_force_o <= 1'b0;
         dig_range_o       <= '0;
      end else begin
         sticky_q          <= (report ? '0 : sticky_q) | new_err;
         pend_q            <= reset_req || (pend_q && !fire);
         dig_reset_o       <= fire;
         test_pulse_o      <= pulse_req;
         dig_range_force_o <= force_range_en;
         dig_range_o       <= force_range_val;
      end
   end

   qsync_frame_pack #(.BXW(BXW), .PATTERN(PATTERN)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .pattern_en (pattern_en),
      .smp_a      (smp[0]),
      .smp_b      (smp[1]),
      .err_field  (err_field),
      .bx         (bx),
      .frame_o    (frame_o)
   );

   a_r8_reset_slot: assert property (@(posedge clk) disable iff (!rst_n)
      dig_reset_o |-> ($past(bx) == RST_SLOT));
   a_r8_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
      dig_reset_o |=> !dig_reset_o);
   a_r9_report_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pattern_en) && (frame_o[19:18] != '0)) |-> ($past(bx) == REP_SLOT));
   a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_req |=> test_pulse_o);
   a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
      force_range_en |=> (dig_range_force_o && dig_range_o == $past(force_range_val)));
endmodule

// File: tb/dual_digitizer_sync_bench.sv
`timescale 1ns/1ps
module dual_digitizer_sync_bench;
   localparam int OL  = 64;
   localparam int RBX = 10;
   localparam int PBX = 40;
   localparam logic [31:0] PAT = 32'hC33C_9669;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  a_w = '0, b_w = '0;
   logic        orb = 1'b0, fen = 1'b0, pat = 1'b0, rreq = 1'b0, preq = 1'b0;
   logic [1:0]  fval = '0;
   logic [31:0] frame;
   logic        rf, drst, tp;
   logic [1:0]  rv;

   int vectors = 0, fails = 0;
   bit done = 0;

   // model state
   int mbx = 0, sticky = 0, pend = 0, va = 0, pa = 0, vb = 0, pb = 0;
   int e_rst = 0, e_tp = 0, e_rf = 0, e_rv = 0, e_pat = 0;
   logic [31:0] e_frame = '0;

   // stimulus state
   int st_cap = 0, b_off = 0, orb_force = 0, was_rst = 0;

   always #4 clk = ~clk;

   dual_digitizer_sync #(.ORBIT_LEN(OL), .RESET_BX(RBX), .REPORT_BX(PBX), .PATTERN(PAT))
   u_dual_digitizer_sync (
      .clk(clk), .rst_n(rst_n), .ch_a_word(a_w), .ch_b_word(b_w), .orbit_mark(orb),
      .force_range_en(fen), .force_range_val(fval), .pattern_en(pat),
      .reset_req(rreq), .pulse_req(preq), .frame_o(frame),
      .dig_range_force_o(rf), .dig_range_o(rv), .dig_reset_o(drst), .test_pulse_o(tp));

   task automatic chk(string tag, longint act, longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (cycle bx=%0d)", tag, act, exp, mbx);
      end
   endtask

   task automatic compare();
      if (e_pat != 0) chk("R7 pattern frame", frame, e_frame);
      else begin
         chk("R1 samples", frame[17:0], e_frame[17:0]);
         chk("R4 counter field", frame[31:20], e_frame[31:20]);
         chk("R2 R3 R9 capid error bit", frame[18], e_frame[18]);
         chk("R5 R9 bunch error bit", frame[19], e_frame[19]);
      end
      chk("R8 digitizer reset", drst, e_rst);
      chk("R10 test pulse", tp, e_tp);
      chk("R6 range force", {rf, rv}, {e_rf[0], e_rv[1:0]});
   endtask

   // one crossing: drive inputs, advance the model, clock, compare
   task automatic tick();
      int ca, cb, err0, err1, rep, fire;
      ca = st_cap % 4;
      cb = (st_cap + b_off) % 4;
      a_w = {ca[1:0], 2'(vectors), 5'(vectors * 7)};
      b_w = {cb[1:0], 2'(vectors + 1), 5'(vectors * 3 + 1)};
      orb = (orb_force != 0) || (mbx == 0);
      err0 = 0;
      if (e_rst == 0) begin
         if (ca != cb) err0 = 1;
         if (va != 0 && ca != (pa + 1) % 4) err0 = 1;
         if (vb != 0 && cb != (pb + 1) % 4) err0 = 1;
      end
      err1 = (orb && mbx != 0) ? 1 : 0;
      rep  = (mbx == PBX) ? 1 : 0;
      e_pat = pat;
      if (pat) e_frame = PAT;
      else e_frame = {12'(mbx), (rep != 0) ? sticky[1:0] : 2'b00, b_w, a_w};
      sticky = ((rep != 0) ? 0 : sticky) | (err1 << 1) | err0;
      if (e_rst != 0) begin va = 0; vb = 0; end
      else begin va = 1; pa = ca; vb = 1; pb = cb; end
      fire  = (pend != 0 && mbx == RBX) ? 1 : 0;
      pend  = (rreq || (pend != 0 && fire == 0)) ? 1 : 0;
      e_rst = fire;
      e_tp  = preq;
      e_rf  = fen;
      e_rv  = fval;
      mbx   = (mbx == OL - 1) ? 0 : mbx + 1;
      @(posedge clk);
      @(negedge clk);
      compare();
      st_cap++;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset frame", frame, 0);
      chk("R11 reset outputs", {rf, rv, drst, tp}, 0);
      rst_n = 1'b1;
      // clean running over several orbits (R1, R4, R9 zero report)
      run(3 * OL);
      // R2: one channel mismatch
      b_off = 1; tick(); b_off = 0;
      run(OL);
      // R3: both channels skip one ID together
      st_cap++; tick();
      run(OL);
      // R5: orbit marker on a wrong crossing
      run(5); orb_force = 1; tick(); orb_force = 0;
      run(OL);
      // R7 pattern, R6 range force, R10 pulse
      pat = 1; run(6); pat = 0;
      fen = 1; fval = 2'd3; tick(); fval = 2'd1; tick(); fval = 2'd2; tick(); fen = 0; fval = 0;
      preq = 1; tick(); preq = 0; tick();
      // R8 reset request, then a capacitor-ID restart that must not be flagged (R3)
      rreq = 1; tick(); rreq = 0;
      for (int i = 0; i < 2 * OL; i++) begin
         if (was_rst != 0) st_cap += 3;
         was_rst = e_rst;
         tick();
      end
      // R9: error raised on the report crossing itself waits one orbit
      while (mbx != PBX) tick();
      b_off = 2; tick(); b_off = 0;
      run(2 * OL);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule